// File: doc/BRIEF.md
# Pairwise Averaging Stream Filter

This block reduces a fixed-length frame of signed fixed-point samples to a stream of pairwise averages. It begins each frame by publishing a constant sample-fetch address and pulsing a one-cycle start strobe. An external agent responds to that address by supplying samples over a valid/ready input handshake.

Samples are taken in order. The first sample of each pair is added into an accumulator. When the second sample arrives, the block forms the sum, halves it, clears the accumulator and presents the result on a valid/ready output. Only one unaccepted result can exist at a time, so the input is closed while a result waits.

After the last pair of a frame has been accepted, the block publishes the address again and starts the next frame. A stall on either side simply holds the block in place until the handshake completes.

Top module: `pair_avg_filter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block enters its idle state: `in_ready`, `out_valid` and `fetch_start` are low and `fetch_addr` is 0. Reset is synchronous and active high.
- R2: The block waits one cycle after reset is released. In the following cycle `fetch_start` is high for exactly one cycle, `fetch_addr` holds 1152 (a base of 1024 plus an offset of 128) and `in_ready` stays low.
- R3: `in_ready` rises in the cycle right after the `fetch_start` cycle. A sample is taken on a rising edge where `in_valid` and `in_ready` are both high.
- R4: Each frame has accepted-sample indices 0, 1, 2 and so on. After each odd-indexed sample, `out_data` equals floor((a+b)/2), where a and b are the two samples of the pair. The input format is 8-bit two's complement with 7 fraction bits. The output format is 19-bit two's complement with 15 fraction bits. As integers, this gives `out_data` = (a+b)*128.
- R5: While `out_valid` is high, `in_ready` is low. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values.
- R6: While `in_valid` is low, the block takes no sample, raises no output and keeps `in_ready` high.
- R7: A frame is 128 accepted samples, giving 64 results. When the 64th result is accepted, the next cycle carries a new `fetch_start` pulse with address 1152. The next frame begins with an empty accumulator.
- R8: `out_valid` rises only in the cycle after an odd-indexed sample is accepted. It never rises after an even-indexed sample.
- R9: A reset in the middle of a frame discards the partial pair and the frame position. After release, the block restarts from the R2 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is present |
| in_data | input | 8 | Input sample, signed, 7 fraction bits |
| in_ready | output | 1 | Block can take a sample |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 19 | Pairwise average, signed, 15 fraction bits |
| fetch_addr | output | 16 | Sample-fetch address published for the frame |
| fetch_start | output | 1 | One-cycle strobe marking the address write |

## Verification
The bound checker watches the handshake rules on every cycle:
- the start strobe carries the fixed address and is followed at once by an open input;
- results stay stable under backpressure;
- the input is closed while a result waits;
- a result only ever follows an accepted sample at an even running count;
- each frame after the first spans exactly 128 accepted samples.

Only the bench's scenarios can show the following:
- the arithmetic values of the averages, including the extreme negative and mixed-sign pairs;
- the one-cycle wait after reset;
- that a mid-frame reset or a frame boundary leaves nothing behind in the accumulator.

// File: rtl/pavg_pkg.sv
package pavg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_RUN  = 2'd2,
        ST_HOLD = 2'd3
    } pavg_state_e;

endpackage

// File: rtl/pavg_align.sv
// Widens a signed fixed-point sample into the accumulator format,
// lining up the binary points.
module pavg_align #(
    parameter int IN_W     = 8,
    parameter int IN_FRAC  = 7,
    parameter int ACC_W    = 19,
    parameter int ACC_FRAC = 15
) (
    input  logic [IN_W-1:0]         din,
    output logic signed [ACC_W-1:0] dout
);
    localparam int SHIFT = ACC_FRAC - IN_FRAC;

    logic signed [ACC_W-1:0] ext;

    assign ext  = {{(ACC_W-IN_W){din[IN_W-1]}}, din};
    assign dout = ext <<< SHIFT;
endmodule

// File: rtl/pavg_halve.sv
// Divides a signed value by two, rounding toward negative infinity.
module pavg_halve #(
    parameter int W = 19
) (
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    assign dout = din >>> 1;
endmodule

// File: rtl/pair_avg_filter.sv
module pair_avg_filter #(
    parameter int IN_W      = 8,
    parameter int IN_FRAC   = 7,
    parameter int ACC_W     = 19,
    parameter int ACC_FRAC  = 15,
    parameter int FRAME_LEN = 128,   // must be even
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 1024,
    parameter int ADDR_OFS  = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ACC_W-1:0]  out_data,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_start
);
    import pavg_pkg::*;

    localparam int                CNT_W      = $clog2(FRAME_LEN);
    localparam logic [CNT_W-1:0]  LAST_IDX   = CNT_W'(FRAME_LEN - 1);
    localparam logic [ADDR_W-1:0] FETCH_ADDR = ADDR_W'(BASE_ADDR + ADDR_OFS);

    typedef struct packed {
        pavg_state_e             st;
        logic [CNT_W-1:0]        idx;
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] res;
        logic [ADDR_W-1:0]       addr;
        logic                    last;
    } regs_t;

    regs_t r_q, r_d;

    logic signed [ACC_W-1:0] sample_al;
    logic signed [ACC_W-1:0] pair_sum;
    logic signed [ACC_W-1:0] pair_avg;

    pavg_align #(
        .IN_W    (IN_W),
        .IN_FRAC (IN_FRAC),
        .ACC_W   (ACC_W),
        .ACC_FRAC(ACC_FRAC)
    ) u_align (
        .din (in_data),
        .dout(sample_al)
    );

    assign pair_sum = r_q.acc + sample_al;

    pavg_halve #(
        .W(ACC_W)
    ) u_halve (
        .din (pair_sum),
        .dout(pair_avg)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.st   = ST_ADDR;
                r_d.addr = FETCH_ADDR;
            end
            ST_ADDR: begin
                r_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (in_valid) begin
                    r_d.idx = (r_q.idx == LAST_IDX) ? '0 : r_q.idx + 1'b1;
                    if (r_q.idx[0]) begin
                        r_d.res  = pair_avg;
                        r_d.acc  = '0;
                        r_d.last = (r_q.idx == LAST_IDX);
                        r_d.st   = ST_HOLD;
                    end else begin
                        r_d.acc = pair_sum;
                    end
                end
            end
            ST_HOLD: begin
                if (out_ready) begin
                    if (r_q.last) begin
                        r_d.st   = ST_ADDR;
                        r_d.addr = FETCH_ADDR;
                        r_d.last = 1'b0;
                    end else begin
                        r_d.st = ST_RUN;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= ST_IDLE;
            r_q.idx  <= '0;
            r_q.acc  <= '0;
            r_q.res  <= '0;
            r_q.addr <= '0;
            r_q.last <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready    = (r_q.st == ST_RUN);
    assign out_valid   = (r_q.st == ST_HOLD);
    assign out_data    = r_q.res;
    assign fetch_addr  = r_q.addr;
    assign fetch_start = (r_q.st == ST_ADDR);
endmodule

// File: rtl/pavg_checker.sv
module pavg_checker #(
    parameter int IN_W      = 8,
    parameter int ACC_W     = 19,
    parameter int FRAME_LEN = 128,
    parameter int ADDR_W    = 16,
    parameter int BASE_ADDR = 1024,
    parameter int ADDR_OFS  = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [IN_W-1:0]   in_data,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ACC_W-1:0]  out_data,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              fetch_start
);
    localparam int                CW        = $clog2(FRAME_LEN) + 1;
    localparam logic [CW-1:0]     FRAME_CNT = CW'(FRAME_LEN);
    localparam logic [ADDR_W-1:0] EXP_ADDR  = ADDR_W'(BASE_ADDR + ADDR_OFS);

    logic [CW-1:0] taken_q;
    logic          framed_q;
    logic [IN_W-1:0] unused_data;

    assign unused_data = in_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            taken_q  <= '0;
            framed_q <= 1'b0;
        end else if (fetch_start) begin
            taken_q  <= '0;
            framed_q <= 1'b1;
        end else if (in_valid && in_ready) begin
            taken_q <= taken_q + 1'b1;
        end
    end

    AST_ADDR_VALUE: assert property (@(posedge clk) disable iff (rst)
        fetch_start |-> (fetch_addr == EXP_ADDR) && !in_ready); // R2

    AST_START_THEN_OPEN: assert property (@(posedge clk) disable iff (rst)
        fetch_start |=> !fetch_start && in_ready); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data)); // R5

    AST_CLOSED_WHILE_HELD: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R5

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        (fetch_start && framed_q) |-> (taken_q == FRAME_CNT)); // R7

    AST_OUT_AFTER_IN: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready)); // R8

    AST_PAIR_ODD: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (taken_q[0] == 1'b0) && (taken_q != '0)); // R4
endmodule

bind pair_avg_filter pavg_checker #(
    .IN_W     (IN_W),
    .ACC_W    (ACC_W),
    .FRAME_LEN(FRAME_LEN),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .ADDR_OFS (ADDR_OFS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .fetch_addr (fetch_addr),
    .fetch_start(fetch_start)
);

// File: tb/pair_avg_filter_tb.sv
module pair_avg_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int PAIRS      = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [18:0] out_data;
    logic [15:0] fetch_addr;
    logic        fetch_start;

    int n_chk = 0;
    int n_err = 0;
    int pairs = 0;
    int fetch_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_avg_filter u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .fetch_addr(fetch_addr), .fetch_start(fetch_start)
    );

    always @(negedge clk) if (!rst && fetch_start) fetch_seen++;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint avg_of(input int a, input int b);
        logic signed [18:0] v;
        v = 19'((a + b) * 128);
        return longint'(v);
    endfunction

    task automatic push(input int x);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'(x);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pop(input string req, input longint exp);
        while (!out_valid) @(negedge clk);
        chk(req, longint'($signed(out_data)), exp);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic do_pair(input int a, input int b);
        push(a);
        chk("R8 no result after even sample", out_valid, 0);
        push(b);
        chk("R8 result after odd sample", out_valid, 1);
        pop("R4 pair average", avg_of(a, b));
        pairs++;
    endtask

    task automatic t_reset_state();
        chk("R1 in_ready in reset", in_ready, 0);
        chk("R1 out_valid in reset", out_valid, 0);
        chk("R1 fetch_start in reset", fetch_start, 0);
        chk("R1 fetch_addr in reset", fetch_addr, 0);
    endtask

    task automatic t_startup();
        rst = 1'b0;
        @(negedge clk);
        chk("R2 fetch_start after wait", fetch_start, 1);
        chk("R2 fetch_addr value", fetch_addr, 1152);
        chk("R2 in_ready low with strobe", in_ready, 0);
        @(negedge clk);
        chk("R3 strobe one cycle", fetch_start, 0);
        chk("R3 in_ready opens", in_ready, 1);
        pairs = 0;
    endtask

    task automatic t_pairs();
        do_pair(64, 64);
        do_pair(-128, -128);
        do_pair(127, -128);
        do_pair(1, 2);
        do_pair(-1, -2);
    endtask

    task automatic t_stall();
        repeat (8) begin
            @(negedge clk);
            chk("R6 idle no output", out_valid, 0);
            chk("R6 idle in_ready held", in_ready, 1);
        end
        push(33);
        repeat (6) begin
            @(negedge clk);
            chk("R6 mid-pair stall no output", out_valid, 0);
        end
        push(-7);
        pop("R6 average across stall", avg_of(33, -7));
        pairs++;
    endtask

    task automatic t_backpressure();
        push(90);
        push(-30);
        repeat (5) begin
            @(negedge clk);
            chk("R5 out_valid held", out_valid, 1);
            chk("R5 in_ready closed", in_ready, 0);
            chk("R5 out_data held", longint'($signed(out_data)), avg_of(90, -30));
        end
        pop("R5 value after backpressure", avg_of(90, -30));
        pairs++;
    endtask

    task automatic t_frame();
        while (pairs < PAIRS - 1) do_pair(pairs % 50 - 20, 3 * (pairs % 11));
        chk("R7 no restart before frame end", fetch_seen, 1);
        push(100);
        push(-60);
        pop("R7 last pair", avg_of(100, -60));
        chk("R7 restart strobe", fetch_start, 1);
        chk("R7 restart address", fetch_addr, 1152);
        @(negedge clk);
        pairs = 0;
        do_pair(5, 7);
        chk("R7 frames seen", fetch_seen, 2);
    endtask

    task automatic t_midreset();
        push(100);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 in_ready after reset", in_ready, 0);
        chk("R9 out_valid after reset", out_valid, 0);
        chk("R9 fetch_addr after reset", fetch_addr, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 restart strobe", fetch_start, 1);
        @(negedge clk);
        pairs = 0;
        do_pair(-4, 10);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_startup();
        t_pairs();
        t_stall();
        t_backpressure();
        t_frame();
        t_midreset();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule